// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is the watchdog of a small microcontroller. A timeout counter advances on every cycle in which a slow-clock tick enable is high. If software does not restart it in time, it either raises an interrupt request or sends a one-cycle system reset pulse. When it resets, it also latches a cause flag that software can read after the restart. The CPU restarts the count with a one-cycle strobe, produced when it executes its watchdog-reset instruction.

Two byte-wide registers sit on a plain write/read bus: a control register at address 0 and a reset-status register at address 1. The enable bit and the timeout code are protected. Software must first write a pattern that opens a short unlock window, and then make the real change within a fixed number of CPU cycles. Stray writes therefore cannot switch the watchdog off. In interrupt mode, every expiry clears the interrupt-enable bit in hardware. If software does not re-arm it, the next expiry escalates to a system reset.

Top module: `wdog_guarded`

## Requirements
- R1: After reset, the control register and the reset-status register both read 0x00, no pulse is driven, and the timeout code is 0.
- R2: When enabled, the timeout is BASE << code ticks. The code is the 4-bit value made of control bits 2:0 (low part) and bit 5 (top bit). Codes above 9 act as code 9, yet read back as written.
- R3: The timeout counter advances only on cycles with the tick enable high. Without ticks it never expires.
- R4: A control write with bit 4 and bit 3 both set opens an unlock window. The next control write that lands within WIN cycles of it loads enable (bit 3), code and interrupt enable (bit 6), and then closes the window. A control write that arrives later changes neither the enable nor the code.
- R5: Control bit 4 reads 1 from the unlock write until WIN cycles have passed, and reads 0 at all other times. Bit 7 always reads 0.
- R6: Outside a window, a control write can change only the interrupt-enable bit. The enable bit and the code stay as they were.
- R7: While the enable bit is 0, the block never drives an interrupt or reset pulse.
- R8: A restart strobe clears the counter, so a full timeout must pass before expiry. An accepted protected change also restarts the count.
- R9: An expiry with the interrupt enable at 0 drives sys_rst_o for one cycle and sets the flag in bit 3 of the status register.
- R10: An expiry with the interrupt enable at 1 drives irq_o for one cycle instead of a reset, and clears the interrupt enable. The next expiry is then a reset.
- R11: The status flag is cleared only by a status write with bit 3 at 0. A write with bit 3 at 1 leaves the flag alone, and a new watchdog reset keeps it set.
- R12: irq_o and sys_rst_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Slow-clock tick enable |
| wdr_i | input | 1 | Restart strobe from the watchdog-reset instruction |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register select: 0 control, 1 status |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | One-cycle watchdog interrupt request |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
The assertions take for granted that a write strobe lasts one cycle and that the bus address is stable while the strobe is high. They also assume the restart strobe and the tick enable are plain synchronous levels. The bench meets these assumptions by driving every input on the falling edge, giving each write exactly one rising edge, and holding the tick low whenever it is not measuring a timeout. The bench measures each timeout by counting the ticks it delivers until a pulse appears. Because it controls every tick, it can compare that count directly against BASE << code.

// File: rtl/wdog_pkg.sv
// Package: wdog_pkg
// Shared field positions, register addresses and the configuration record
// for the guarded watchdog. Assumes an 8-bit register bus.
package wdog_pkg;

    localparam int DATA_W   = 8;
    localparam int CODE_W   = 4;

    // control register field positions (software-visible layout)
    localparam int F_CODE_LO = 0;   // code bits 2:0 at 2:0
    localparam int F_EN      = 3;
    localparam int F_UNLOCK  = 4;
    localparam int F_CODE_HI = 5;   // code bit 3
    localparam int F_IE      = 6;

    // status register flag position
    localparam int F_WDFLAG  = 3;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    typedef struct packed {
        logic              ie;
        logic              en;
        logic [CODE_W-1:0] code;
    } wdog_cfg_t;

    // extract the 4-bit timeout code from a control byte
    function automatic logic [CODE_W-1:0] code_of(input logic [DATA_W-1:0] d);
        return {d[F_CODE_HI], d[F_CODE_LO+2:F_CODE_LO]};
    endfunction

endpackage

// File: rtl/wdog_unlock.sv
// Module: wdog_unlock
// Tracks the timed unlock window. An unlock write (unlock and enable bits
// both set, window closed) loads WIN; the window stays open while the
// count is non-zero. A control write while open is the protected change
// and closes the window. Assumes one-cycle write strobes.
module wdog_unlock
    import wdog_pkg::*;
#(
    parameter int WIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              win_open,
    output logic              prot_wr,
    output logic              unlock_wr
);

    localparam int WW = $clog2(WIN + 1);

    logic [WW-1:0] win_cnt;

    // window is open while the countdown is running
    always_comb win_open = (win_cnt != '0);

    // classify the current control write
    always_comb begin
        prot_wr   = ctrl_wr && win_open;
        unlock_wr = ctrl_wr && !win_open && wdata[F_UNLOCK] && wdata[F_EN];
    end

    // countdown of the remaining window cycles
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_cnt <= '0;
        else if (prot_wr)
            win_cnt <= '0;
        else if (unlock_wr)
            win_cnt <= WW'(WIN);
        else if (win_open)
            win_cnt <= win_cnt - 1'b1;
    end

endmodule

// File: rtl/wdog_regs.sv
// Module: wdog_regs
// Holds the configuration (enable, code, interrupt enable) and the
// watchdog-reset flag. Enable and code change only on a protected write;
// the interrupt enable is writable at any time and is cleared by an
// interrupt-mode expiry. Assumes the fire inputs are one-cycle events.
module wdog_regs
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              stat_wr,
    input  logic              prot_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              irq_fire,
    input  logic              rst_fire,
    output wdog_cfg_t         cfg,
    output logic              rst_flag
);

    // configuration update: protected fields, free interrupt enable, hw clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else begin
            if (prot_wr) begin
                cfg.en   <= wdata[F_EN];
                cfg.code <= code_of(wdata);
            end
            if (ctrl_wr)
                cfg.ie <= wdata[F_IE];
            if (irq_fire)
                cfg.ie <= 1'b0;
        end
    end

    // reset-cause flag: set by expiry, cleared only by writing 0
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_flag <= 1'b0;
        else if (rst_fire)
            rst_flag <= 1'b1;
        else if (stat_wr && !wdata[F_WDFLAG])
            rst_flag <= 1'b0;
    end

endmodule

// File: rtl/wdog_timer.sv
// Module: wdog_timer
// Timeout counter. Advances on tick while enabled; clears on restart, on a
// configuration change and when disabled. Signals expiry on the tick that
// completes BASE << min(code, MAX_CODE) ticks. Assumes BASE is a power of two.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int BASE     = 2048,
    parameter int MAX_CODE = 9,
    parameter int CW       = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    input  logic              restart,
    input  logic              clear,
    output logic              expire,
    output logic [CW-1:0]     cnt,
    output logic [CW-1:0]     tmo
);

    logic [CODE_W-1:0] eff_code;
    logic              at_end;

    // saturate reserved codes to the longest timeout
    always_comb eff_code = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;

    // selected timeout length in ticks
    always_comb tmo = CW'(BASE) << eff_code;

    // expiry on the tick that completes the period
    always_comb begin
        at_end = (cnt == tmo - CW'(1));
        expire = en && tick && !restart && !clear && at_end;
    end

    // tick counter with restart priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en || restart || clear)
            cnt <= '0;
        else if (tick)
            cnt <= at_end ? '0 : cnt + CW'(1);
    end

endmodule

// File: rtl/wdog_guarded.sv
// Module: wdog_guarded
// Top of the guarded watchdog: register decode and read mux, unlock
// window, configuration, timeout counter and registered output pulses.
// Assumes a single-cycle write strobe and a combinational read path.
module wdog_guarded
    import wdog_pkg::*;
#(
    parameter int BASE     = 2048,
    parameter int MAX_CODE = 9,
    parameter int WIN      = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       wdr_i,
    input  logic       bus_we_i,
    input  logic       bus_addr_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o,
    output logic       irq_o,
    output logic       sys_rst_o
);

    localparam int CW = $clog2(BASE << MAX_CODE) + 1;

    logic              ctrl_wr, stat_wr;
    logic              win_open, prot_wr, unlock_wr;
    logic              expire, irq_fire, rst_fire, rst_flag;
    wdog_cfg_t         cfg;
    logic [CW-1:0]     cnt, tmo;
    logic              irq_q, rst_q;

    // address decode of bus writes
    always_comb begin
        ctrl_wr = bus_we_i && (bus_addr_i == ADDR_CTRL);
        stat_wr = bus_we_i && (bus_addr_i == ADDR_STAT);
    end

    wdog_unlock #(.WIN(WIN)) u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .wdata     (bus_wdata_i),
        .win_open  (win_open),
        .prot_wr   (prot_wr),
        .unlock_wr (unlock_wr)
    );

    wdog_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .stat_wr  (stat_wr),
        .prot_wr  (prot_wr),
        .wdata    (bus_wdata_i),
        .irq_fire (irq_fire),
        .rst_fire (rst_fire),
        .cfg      (cfg),
        .rst_flag (rst_flag)
    );

    wdog_timer #(.BASE(BASE), .MAX_CODE(MAX_CODE), .CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_i),
        .en      (cfg.en),
        .code    (cfg.code),
        .restart (wdr_i),
        .clear   (prot_wr),
        .expire  (expire),
        .cnt     (cnt),
        .tmo     (tmo)
    );

    // route an expiry to interrupt or reset by the interrupt enable
    always_comb begin
        irq_fire = expire && cfg.ie;
        rst_fire = expire && !cfg.ie;
    end

    // registered one-cycle output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            rst_q <= 1'b0;
        end else begin
            irq_q <= irq_fire;
            rst_q <= rst_fire;
        end
    end

    assign irq_o     = irq_q;
    assign sys_rst_o = rst_q;

    // read mux for the two registers
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_CTRL) begin
            bus_rdata_o[F_CODE_LO+2:F_CODE_LO] = cfg.code[2:0];
            bus_rdata_o[F_EN]                  = cfg.en;
            bus_rdata_o[F_UNLOCK]              = win_open;
            bus_rdata_o[F_CODE_HI]             = cfg.code[3];
            bus_rdata_o[F_IE]                  = cfg.ie;
        end else begin
            bus_rdata_o[F_WDFLAG] = rst_flag;
        end
    end

endmodule

// File: rtl/wdog_guarded_chk.sv
// Module: wdog_guarded_chk
// Checker bound to wdog_guarded. Assumes one-cycle write strobes.
module wdog_guarded_chk #(
    parameter int CW = 21
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_o,
    input logic          sys_rst_o,
    input logic          en,
    input logic          ie,
    input logic [3:0]    code,
    input logic          win_open,
    input logic          prot_wr,
    input logic          unlock_wr,
    input logic          rst_flag,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] tmo
);

    // R12: interrupt and reset pulses are exclusive
    p_pulse_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({irq_o, sys_rst_o}) <= 1);

    // R9: a reset pulse is accompanied by the set cause flag
    p_rst_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> rst_flag);

    // R10: after an interrupt the interrupt enable is clear
    p_irq_clears_ie_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !ie);

    // R7: no pulse unless the watchdog was enabled
    p_quiet_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || sys_rst_o) |-> $past(en));

    // R5: the window opens only on an unlock write
    p_window_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> $past(unlock_wr));

    // R4, R6: enable and code move only after a protected write
    p_guarded_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(prot_wr) |-> ($stable(en) && $stable(code)));

    // R2: counter stays below the selected timeout
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < tmo);

endmodule

bind wdog_guarded wdog_guarded_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .sys_rst_o (sys_rst_o),
    .en        (cfg.en),
    .ie        (cfg.ie),
    .code      (cfg.code),
    .win_open  (win_open),
    .prot_wr   (prot_wr),
    .unlock_wr (unlock_wr),
    .rst_flag  (rst_flag),
    .cnt       (cnt),
    .tmo       (tmo)
);

// File: tb/wdog_guarded_bench.sv
`timescale 1ns/1ps
module wdog_guarded_bench;

    localparam int BASE = 4;
    localparam int MAXC = 9;
    localparam int WIN  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0, wdr_i = 1'b0, bus_we_i = 1'b0, bus_addr_i = 1'b0;
    logic [7:0] bus_wdata_i = '0;
    logic [7:0] bus_rdata_o;
    logic       irq_o, sys_rst_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    wdog_guarded #(.BASE(BASE), .MAX_CODE(MAXC), .WIN(WIN)) u_wdog_guarded (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wdr_i(wdr_i),
        .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .sys_rst_o(sys_rst_o));

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
        @(negedge clk);
        bus_we_i = 1'b0;
    endtask

    task automatic rd(input logic a, output int v);
        bus_addr_i = a;
        #1 v = int'(bus_rdata_o);
    endtask

    task automatic setcfg(input logic [7:0] d);
        wr(1'b0, 8'h18);
        wr(1'b0, d);
    endtask

    function automatic logic [7:0] cbits(input int c);
        return 8'((c & 7) | (((c >> 3) & 1) << 5));
    endfunction

    function automatic int tmo_of(input int c);
        return BASE << ((c > MAXC) ? MAXC : c);
    endfunction

    // tick every 'period' cycles (0 = never) until a pulse or limit
    task automatic measure(input int period, input int limit, output int ticks,
                           output bit got_irq, output bit got_rst);
        ticks = 0; got_irq = 0; got_rst = 0;
        for (int c = 0; c < limit; c++) begin
            if (period != 0 && (c % period) == 0) begin
                tick_i = 1'b1; ticks++;
            end else
                tick_i = 1'b0;
            @(negedge clk);
            if (irq_o || sys_rst_o) begin
                got_irq = irq_o; got_rst = sys_rst_o;
                break;
            end
        end
        tick_i = 1'b0;
    endtask

    initial begin
        #(10 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        if (!done) begin
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v, t, exp;
        bit gi, gr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(1'b0, v); chk(v == 0, "R1 ctrl", v, 0);
        rd(1'b1, v); chk(v == 0, "R1 stat", v, 0);
        chk(!irq_o && !sys_rst_o, "R1 pulses", int'({irq_o, sys_rst_o}), 0);

        // R1: code 0 after reset, enabling only
        wr(1'b0, 8'h18); wr(1'b0, 8'h08);
        measure(1, 5000, t, gi, gr);
        chk(gr && t == BASE, "R1 default timeout", t, BASE);

        // R2, R9: sweep every code
        for (int c = 0; c < 16; c++) begin
            setcfg(8'h08 | cbits(c));
            rd(1'b0, v);
            chk(v == int'(8'h08 | cbits(c)), "R2 readback", v, int'(8'h08 | cbits(c)));
            measure(1, 5000, t, gi, gr);
            exp = tmo_of(c);
            chk(gr && !gi && t == exp, "R2 R9 timeout", t, exp);
            rd(1'b1, v); chk(v == 8'h08, "R9 flag", v, 8);
        end

        // R11: flag write rules
        wr(1'b1, 8'h08); rd(1'b1, v); chk(v == 8'h08, "R11 write one keeps", v, 8);
        wr(1'b1, 8'hF7); rd(1'b1, v); chk(v == 0, "R11 write zero clears", v, 0);

        // R5: unlock bit visibility
        setcfg(8'h08);
        wr(1'b0, 8'h18);
        rd(1'b0, v); chk(v[4] == 1, "R5 open after unlock", v, 8'h18);
        repeat (3) @(negedge clk);
        rd(1'b0, v); chk(v[4] == 1, "R5 open at last cycle", v, 8'h18);
        @(negedge clk);
        rd(1'b0, v); chk(v == 8'h08, "R5 closed", v, 8'h08);

        // R4: window length sweep
        for (int g = 0; g < 7; g++) begin
            setcfg(8'h08);
            wr(1'b0, 8'h18);
            repeat (g) @(negedge clk);
            wr(1'b0, 8'h0D);
            measure(1, 5000, t, gi, gr);
            exp = (g + 1 <= WIN) ? tmo_of(5) : tmo_of(0);
            chk(gr && t == exp, "R4 window", t, exp);
        end

        // R6: code write without unlock ignored
        setcfg(8'h08);
        wr(1'b0, 8'h07);
        measure(1, 5000, t, gi, gr);
        chk(gr && t == BASE, "R6 code guarded", t, BASE);
        wr(1'b0, 8'h00);
        rd(1'b0, v); chk(v == 8'h08, "R6 disable guarded", v, 8'h08);

        // R7: disabled stays silent
        setcfg(8'h00);
        measure(1, 3000, t, gi, gr);
        chk(!gi && !gr, "R7 disabled", int'({gi, gr}), 0);
        wr(1'b0, 8'h08);
        rd(1'b0, v); chk(v == 0, "R6 enable guarded", v, 0);
        wr(1'b0, 8'h40);
        rd(1'b0, v); chk(v == 8'h40, "R6 ie free", v, 8'h40);
        wr(1'b0, 8'h00);

        // R3: no tick, no expiry; sparse ticks
        setcfg(8'h08 | cbits(1));
        measure(0, 500, t, gi, gr);
        chk(!gi && !gr, "R3 no tick", int'({gi, gr}), 0);
        measure(3, 5000, t, gi, gr);
        chk(gr && t == tmo_of(1), "R3 sparse ticks", t, tmo_of(1));

        // R8: restart strobe
        setcfg(8'h08 | cbits(3));
        gi = 0; gr = 0;
        tick_i = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (irq_o || sys_rst_o) gr = 1;
        end
        wdr_i = 1'b1;
        @(negedge clk);
        wdr_i = 1'b0; tick_i = 1'b0;
        chk(!gr, "R8 no early expiry", int'(gr), 0);
        measure(1, 5000, t, gi, gr);
        chk(gr && t == tmo_of(3), "R8 restart", t, tmo_of(3));

        // R10: interrupt then reset
        wr(1'b1, 8'h00);
        setcfg(8'h48 | cbits(2));
        measure(1, 5000, t, gi, gr);
        chk(gi && !gr && t == tmo_of(2), "R10 irq", t, tmo_of(2));
        rd(1'b0, v); chk(v == int'(8'h08 | cbits(2)), "R10 ie cleared", v, int'(8'h08 | cbits(2)));
        rd(1'b1, v); chk(v == 0, "R10 no flag on irq", v, 0);
        measure(1, 5000, t, gi, gr);
        chk(gr && !gi && t == tmo_of(2), "R10 escalation", t, tmo_of(2));
        rd(1'b1, v); chk(v == 8'h08, "R9 R11 flag after escalation", v, 8);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule